// File: doc/BRIEF.md
# I2C Slave Address Matcher

This block is the receive front end of an I2C slave. It brings the SCL and SDA wires into the system clock domain through a synchronizer chain, recognises Start, Repeated Start and Stop, and shifts in the address byte or bytes that follow a Start. For each address byte it decides whether to acknowledge. It compares the byte against a programmed own address through a per-bit don't-care mask. It also recognises the all-zero general-call byte and supports an accept-everything repeater mode. The address may be 7 bits or 10 bits long. When the last address byte is acknowledged, it pulses a match strobe, reports the read/write bit and whether the match was a general call, and can hold SCL low until the host signals that it is ready.

The state machine has six states. IDLE waits for a Start. ADDR shifts in bits on SCL rising edges. ACK drives SDA low for the ninth clock. STRETCH holds SCL low. DONE marks that the address phase is over and the data phase belongs to other logic. SKIP marks a transaction that is not for this slave. The transitions are these:
- start: from any state to ADDR.
- stop: from any state to IDLE.
- byte_ok: ADDR to ACK, on the SCL fall after the eighth bit when the byte is accepted.
- byte_bad: ADDR to SKIP, at the same point when the byte is refused.
- need_low: ACK to ADDR, on the ninth SCL fall after a 10-bit write header.
- ack_end: ACK to STRETCH or DONE, on the ninth SCL fall of the last address byte, depending on the stretch enable.
- ready: STRETCH to DONE, when the release input is high.

Top module: `i2c_addr_match`

## Requirements
- R1: After reset, match_o, rw_o, gc_o, sda_low_o and scl_hold_o are all 0.
- R2: In 7-bit mode (ten_bit_en_i=0), a first byte whose bits 7:1 equal own_addr_i[6:0] is acknowledged: sda_low_o is 1 while SCL is high in the ninth clock, match_o pulses after the ninth SCL fall, and rw_o equals byte bit 0 (1 = read).
- R3: A byte that does not match leaves SDA undriven for the ninth clock and produces no match pulse until the next Start or Stop.
- R4: A 1 in addr_mask_i bit k makes own-address bit k a don't-care; a difference in an unmasked bit still refuses the byte.
- R5: The byte 0x00 is never compared against the own address. It is acknowledged with gc_o=1 and rw_o=0 only when gc_en_i=1, and is refused otherwise.
- R6: With repeater_en_i=1, any first byte is acknowledged and matched, with rw_o taken from its bit 0.
- R7: In 10-bit mode, a write header 11110,A9,A8,0 matching own_addr_i[9:8] is acknowledged without a match pulse. The next byte is acknowledged and matched with rw_o=0 only if it equals own_addr_i[7:0] under the mask.
- R8: In 10-bit mode, a read header 11110,A9,A8,1 is acknowledged and matched with rw_o=1 only if a full 10-bit match has occurred since the last Stop; otherwise it is refused.
- R9: With stretch_en_i=1, scl_hold_o rises together with the match pulse and stays 1 until release_i is sampled high; it falls in the following cycle. With stretch_en_i=0 it stays 0.
- R10: A Start in the middle of a byte restarts the bit count, so the next full byte is decoded afresh. A Stop returns the block to IDLE and clears rw_o and gc_o.
- R11: match_o is a one-cycle pulse. rw_o and gc_o hold their values from the match until the next Start or Stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL wire level |
| sda_i | input | 1 | SDA wire level |
| own_addr_i | input | 10 | Own slave address (bits 6:0 used in 7-bit mode) |
| addr_mask_i | input | 10 | Per-bit don't-care mask, 1 = ignore |
| ten_bit_en_i | input | 1 | Select 10-bit addressing |
| gc_en_i | input | 1 | Accept the general call |
| repeater_en_i | input | 1 | Accept every first address byte |
| stretch_en_i | input | 1 | Hold SCL low after a match |
| release_i | input | 1 | Host ready; ends the SCL hold |
| match_o | output | 1 | One-cycle pulse when the address phase is acknowledged |
| rw_o | output | 1 | Read/write bit of the matched address |
| gc_o | output | 1 | Match was a general call |
| sda_low_o | output | 1 | Pull SDA low (acknowledge) |
| scl_hold_o | output | 1 | Pull SCL low (stretch) |

## Verification
Each wire change passes through two synchronizer flops and one state register, so sda_low_o and scl_hold_o follow the relevant SCL fall by three clock cycles, and match_o pulses three cycles after the ninth SCL fall. The bench master holds each SCL phase for eight cycles. It samples the acknowledge in the middle of the ninth SCL high and checks the stretch a full half-period after the ninth fall, so every sample lands well after its result has settled. A scoreboard queue is loaded with the expected read/write and general-call values before each transaction. A monitor pops an entry on every match pulse, so it catches both a missing match and a spurious one.

// File: rtl/i2c_am_pkg.sv
package i2c_am_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 10;
    localparam logic [4:0] TEN_HDR = 5'b11110;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK,
        ST_STRETCH,
        ST_DONE,
        ST_SKIP
    } am_state_e;
endpackage

// File: rtl/i2c_bus_cond.sv
module i2c_bus_cond #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [1:0] pipe [STAGES];
    logic       scl_q, sda_q, scl_s;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_sync
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    pipe[g] <= 2'b11;
                else if (g == 0)
                    pipe[g] <= {scl_i, sda_i};
                else
                    pipe[g] <= pipe[(g == 0) ? 0 : g - 1];
            end
        end
    endgenerate

    assign scl_s = pipe[STAGES-1][1];
    assign sda_s = pipe[STAGES-1][0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

    p_cond_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_det && stop_det));
endmodule

// File: rtl/i2c_addr_cmp.sv
module i2c_addr_cmp
    import i2c_am_pkg::*;
(
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              second_i,
    input  logic              armed_i,
    input  logic [ADDR_W-1:0] own_addr_i,
    input  logic [ADDR_W-1:0] addr_mask_i,
    input  logic              ten_bit_en_i,
    input  logic              gc_en_i,
    input  logic              repeater_en_i,
    output logic              ack_o,
    output logic              final_o,
    output logic              rw_o,
    output logic              gc_o,
    output logic              arm_o
);
    logic is_gc, is_hdr, hit7, hit_hi, hit_lo;

    assign is_gc  = (rx_byte == '0);
    assign is_hdr = (rx_byte[7:3] == TEN_HDR);
    assign hit7   = (((rx_byte[7:1] ^ own_addr_i[6:0]) & ~addr_mask_i[6:0]) == '0);
    assign hit_hi = (((rx_byte[2:1] ^ own_addr_i[9:8]) & ~addr_mask_i[9:8]) == '0);
    assign hit_lo = (((rx_byte ^ own_addr_i[7:0]) & ~addr_mask_i[7:0]) == '0);

    always_comb begin
        ack_o   = 1'b0;
        final_o = 1'b0;
        rw_o    = 1'b0;
        gc_o    = 1'b0;
        arm_o   = 1'b0;
        if (second_i) begin
            ack_o   = hit_lo;
            final_o = hit_lo;
            arm_o   = hit_lo;
        end else if (is_gc && gc_en_i) begin
            ack_o   = 1'b1;
            final_o = 1'b1;
            gc_o    = 1'b1;
        end else if (repeater_en_i) begin
            ack_o   = 1'b1;
            final_o = 1'b1;
            rw_o    = rx_byte[0];
        end else if (is_gc) begin
            ack_o   = 1'b0;
        end else if (!ten_bit_en_i) begin
            ack_o   = hit7;
            final_o = hit7;
            rw_o    = rx_byte[0];
        end else if (is_hdr && hit_hi) begin
            if (!rx_byte[0]) begin
                ack_o = 1'b1;
            end else begin
                ack_o   = armed_i;
                final_o = armed_i;
                rw_o    = 1'b1;
            end
        end
    end

    always_comb begin
        p_final_needs_ack_r3: assert (!final_o || ack_o);
    end
endmodule

// File: rtl/i2c_match_fsm.sv
module i2c_match_fsm
    import i2c_am_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              stretch_en_i,
    input  logic              release_i,
    input  logic              cmp_ack,
    input  logic              cmp_final,
    input  logic              cmp_rw,
    input  logic              cmp_gc,
    input  logic              cmp_arm,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              second_o,
    output logic              armed_o,
    output logic              match_o,
    output logic              rw_o,
    output logic              gc_o,
    output logic              sda_low_o,
    output logic              scl_hold_o
);
    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);

    am_state_e        state_q, state_d;
    logic [CNT_W-1:0] bit_cnt;
    logic             full, final_q, match_q, rw_q, gc_q, armed_q, second_q;

    assign full = (bit_cnt == CNT_FULL);

    always_comb begin
        state_d = state_q;
        if (stop_det)
            state_d = ST_IDLE;
        else if (start_det)
            state_d = ST_ADDR;
        else begin
            unique case (state_q)
                ST_ADDR:
                    if (scl_fall && full)
                        state_d = cmp_ack ? ST_ACK : ST_SKIP;
                ST_ACK:
                    if (scl_fall)
                        state_d = !final_q ? ST_ADDR :
                                  (stretch_en_i ? ST_STRETCH : ST_DONE);
                ST_STRETCH:
                    if (release_i)
                        state_d = ST_DONE;
                ST_IDLE, ST_DONE, ST_SKIP: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt  <= '0;
            rx_byte  <= '0;
            final_q  <= 1'b0;
            match_q  <= 1'b0;
            rw_q     <= 1'b0;
            gc_q     <= 1'b0;
            armed_q  <= 1'b0;
            second_q <= 1'b0;
        end else begin
            match_q <= 1'b0;
            if (stop_det || start_det) begin
                bit_cnt  <= '0;
                second_q <= 1'b0;
                rw_q     <= 1'b0;
                gc_q     <= 1'b0;
                if (stop_det)
                    armed_q <= 1'b0;
            end else if (state_q == ST_ADDR) begin
                if (scl_rise && !full) begin
                    rx_byte <= {rx_byte[BYTE_W-2:0], sda_s};
                    bit_cnt <= bit_cnt + 1'b1;
                end else if (scl_fall && full && cmp_ack) begin
                    final_q <= cmp_final;
                    armed_q <= armed_q | cmp_arm;
                    if (cmp_final) begin
                        rw_q <= cmp_rw;
                        gc_q <= cmp_gc;
                    end
                end
            end else if (state_q == ST_ACK && scl_fall) begin
                if (final_q) begin
                    match_q <= 1'b1;
                end else begin
                    bit_cnt  <= '0;
                    second_q <= 1'b1;
                end
            end
        end
    end

    always_comb begin
        sda_low_o  = (state_q == ST_ACK);
        scl_hold_o = (state_q == ST_STRETCH);
        match_o    = match_q;
        rw_o       = rw_q;
        gc_o       = gc_q;
        armed_o    = armed_q;
        second_o   = second_q;
    end

    p_ack_after_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_low_o) |-> $past(bit_cnt) == CNT_FULL);
    p_hold_on_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_hold_o) |-> match_o);
    p_hold_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(scl_hold_o) |-> $past(release_i || start_det || stop_det));
    p_match_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        match_o |=> !match_o);
    p_gc_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        gc_o |-> !rw_o);
    p_stop_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (!sda_low_o && !scl_hold_o && !match_o && !rw_o && !gc_o));
    p_lines_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(sda_low_o && scl_hold_o));
endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
    import i2c_am_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [ADDR_W-1:0] own_addr_i,
    input  logic [ADDR_W-1:0] addr_mask_i,
    input  logic              ten_bit_en_i,
    input  logic              gc_en_i,
    input  logic              repeater_en_i,
    input  logic              stretch_en_i,
    input  logic              release_i,
    output logic              match_o,
    output logic              rw_o,
    output logic              gc_o,
    output logic              sda_low_o,
    output logic              scl_hold_o
);
    logic              sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic [BYTE_W-1:0] rx_byte;
    logic              second, armed;
    logic              cmp_ack, cmp_final, cmp_rw, cmp_gc, cmp_arm;

    i2c_bus_cond #(.STAGES(SYNC_STAGES)) u_cond (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_addr_cmp u_cmp (
        .rx_byte       (rx_byte),
        .second_i      (second),
        .armed_i       (armed),
        .own_addr_i    (own_addr_i),
        .addr_mask_i   (addr_mask_i),
        .ten_bit_en_i  (ten_bit_en_i),
        .gc_en_i       (gc_en_i),
        .repeater_en_i (repeater_en_i),
        .ack_o         (cmp_ack),
        .final_o       (cmp_final),
        .rw_o          (cmp_rw),
        .gc_o          (cmp_gc),
        .arm_o         (cmp_arm)
    );

    i2c_match_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .sda_s        (sda_s),
        .scl_rise     (scl_rise),
        .scl_fall     (scl_fall),
        .start_det    (start_det),
        .stop_det     (stop_det),
        .stretch_en_i (stretch_en_i),
        .release_i    (release_i),
        .cmp_ack      (cmp_ack),
        .cmp_final    (cmp_final),
        .cmp_rw       (cmp_rw),
        .cmp_gc       (cmp_gc),
        .cmp_arm      (cmp_arm),
        .rx_byte      (rx_byte),
        .second_o     (second),
        .armed_o      (armed),
        .match_o      (match_o),
        .rw_o         (rw_o),
        .gc_o         (gc_o),
        .sda_low_o    (sda_low_o),
        .scl_hold_o   (scl_hold_o)
    );
endmodule

// File: tb/tb_i2c_addr_match.sv
module tb_i2c_addr_match;
    localparam int H = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1, sda_m = 1'b1;
    logic       scl_bus, sda_bus;
    logic [9:0] own_addr = 10'h02A, addr_mask = '0;
    logic       ten_bit_en = 1'b0, gc_en = 1'b0, repeater_en = 1'b0;
    logic       stretch_en = 1'b0, release_in = 1'b0;
    logic       match_o, rw_o, gc_o, sda_low_o, scl_hold_o;

    int  checks = 0;
    int  fails = 0;
    bit  done = 1'b0;
    bit  prev_match = 1'b0;
    logic [1:0] exp_q [$];

    always #2.5 clk = ~clk;

    assign scl_bus = scl_m & ~scl_hold_o;
    assign sda_bus = sda_m & ~sda_low_o;

    i2c_addr_match dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .scl_i         (scl_bus),
        .sda_i         (sda_bus),
        .own_addr_i    (own_addr),
        .addr_mask_i   (addr_mask),
        .ten_bit_en_i  (ten_bit_en),
        .gc_en_i       (gc_en),
        .repeater_en_i (repeater_en),
        .stretch_en_i  (stretch_en),
        .release_i     (release_in),
        .match_o       (match_o),
        .rw_o          (rw_o),
        .gc_o          (gc_o),
        .sda_low_o     (sda_low_o),
        .scl_hold_o    (scl_hold_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_match(input bit rw, input bit gc);
        exp_q.push_back({rw, gc});
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wait_clk(H);
        scl_m = 1'b1; wait_clk(H);
        sda_m = 1'b0; wait_clk(H);
        scl_m = 1'b0; wait_clk(H);
    endtask

    task automatic bus_stop();
        scl_m = 1'b0; wait_clk(H);
        sda_m = 1'b0; wait_clk(H);
        scl_m = 1'b1; wait_clk(H);
        sda_m = 1'b1; wait_clk(H);
    endtask

    task automatic send_bits(input logic [7:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            sda_m = v[i]; wait_clk(H);
            scl_m = 1'b1; wait_clk(H);
            scl_m = 1'b0; wait_clk(2);
        end
    endtask

    task automatic ninth(output bit acked);
        sda_m = 1'b1; wait_clk(H);
        scl_m = 1'b1; wait_clk(H / 2);
        acked = ~sda_bus;
        wait_clk(H / 2);
        scl_m = 1'b0; wait_clk(H);
    endtask

    task automatic addr_byte(input logic [7:0] b, input bit exp_ack, input string req);
        bit a;
        send_bits(b, 8);
        ninth(a);
        check(a == exp_ack, req, "acknowledge", a, exp_ack);
    endtask

    // Scoreboard monitor: every match pulse consumes one expected entry.
    always @(negedge clk) begin
        if (rst_n) begin
            if (match_o) begin
                check(!prev_match, "R11", "match pulse width", 2, 1);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R3", "unexpected match", 1, 0);
                end else begin
                    logic [1:0] e;
                    e = exp_q.pop_front();
                    check({rw_o, gc_o} == e, "R11", "rw/gc at match",
                          int'({rw_o, gc_o}), int'(e));
                end
            end
            prev_match <= match_o;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        wait_clk(4);
        // R1 reset state
        check({match_o, rw_o, gc_o, sda_low_o, scl_hold_o} == 5'b0, "R1",
              "outputs in reset", int'({match_o, rw_o, gc_o, sda_low_o, scl_hold_o}), 0);
        rst_n = 1'b1;
        wait_clk(4);
        check({match_o, rw_o, gc_o, sda_low_o, scl_hold_o} == 5'b0, "R1",
              "outputs after reset", int'({match_o, rw_o, gc_o, sda_low_o, scl_hold_o}), 0);

        // R2 7-bit write and read
        bus_start(); expect_match(1'b0, 1'b0); addr_byte(8'h54, 1'b1, "R2"); bus_stop();
        bus_start(); expect_match(1'b1, 1'b0); addr_byte(8'h55, 1'b1, "R2");
        check(rw_o == 1'b1, "R11", "rw held after match", rw_o, 1);
        bus_stop();
        check(rw_o == 1'b0, "R10", "rw cleared by stop", rw_o, 0);

        // R3 mismatch
        bus_start(); addr_byte(8'h56, 1'b0, "R3"); bus_stop();

        // R4 mask
        addr_mask = 10'h003;
        bus_start(); expect_match(1'b0, 1'b0); addr_byte(8'h56, 1'b1, "R4"); bus_stop();
        bus_start(); addr_byte(8'h5C, 1'b0, "R4"); bus_stop();
        addr_mask = '0;

        // R5 general call
        bus_start(); addr_byte(8'h00, 1'b0, "R5"); bus_stop();
        gc_en = 1'b1;
        bus_start(); expect_match(1'b0, 1'b1); addr_byte(8'h00, 1'b1, "R5");
        check(gc_o == 1'b1, "R5", "general-call flag", gc_o, 1);
        bus_stop();
        check(gc_o == 1'b0, "R10", "gc cleared by stop", gc_o, 0);
        gc_en = 1'b0;

        // R6 repeater
        repeater_en = 1'b1;
        bus_start(); expect_match(1'b1, 1'b0); addr_byte(8'h3F, 1'b1, "R6"); bus_stop();
        repeater_en = 1'b0;

        // R7 / R8 10-bit
        ten_bit_en = 1'b1; own_addr = 10'h2A5;
        bus_start(); addr_byte(8'hF5, 1'b0, "R8"); bus_stop();
        bus_start(); addr_byte(8'hF4, 1'b1, "R7");
        expect_match(1'b0, 1'b0); addr_byte(8'hA5, 1'b1, "R7");
        bus_start(); expect_match(1'b1, 1'b0); addr_byte(8'hF5, 1'b1, "R8");
        bus_stop();
        bus_start(); addr_byte(8'hF4, 1'b1, "R7"); addr_byte(8'hA4, 1'b0, "R7"); bus_stop();
        ten_bit_en = 1'b0; own_addr = 10'h02A;

        // R9 stretch
        stretch_en = 1'b1;
        bus_start(); expect_match(1'b0, 1'b0); addr_byte(8'h54, 1'b1, "R9");
        scl_m = 1'b1; wait_clk(H);
        check(scl_hold_o == 1'b1, "R9", "SCL held", scl_hold_o, 1);
        check(scl_bus == 1'b0, "R9", "bus SCL low", scl_bus, 0);
        release_in = 1'b1; wait_clk(1);
        release_in = 1'b0; wait_clk(1);
        check(scl_hold_o == 1'b0, "R9", "SCL released", scl_hold_o, 1'b0);
        bus_stop();
        stretch_en = 1'b0;
        bus_start(); expect_match(1'b0, 1'b0); addr_byte(8'h54, 1'b1, "R9");
        scl_m = 1'b1; wait_clk(H);
        check(scl_hold_o == 1'b0, "R9", "no hold when disabled", scl_hold_o, 0);
        bus_stop();

        // R10 start in the middle of a byte
        bus_start(); send_bits(8'h0A, 4);
        bus_start(); expect_match(1'b0, 1'b0); addr_byte(8'h54, 1'b1, "R10"); bus_stop();

        wait_clk(10);
        check(exp_q.size() == 0, "R2", "matches still pending", exp_q.size(), 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule